// File: doc/BRIEF.md
# Multi-Drop Address-Wake Serial Receiver

This block receives asynchronous serial characters on a line shared by several stations. Each character carries one extra bit after the data bits. When that bit is 1 the character is a station address, and when it is 0 the character is payload. The host reads the received byte, the state of the extra bit, a ready flag, framing and overrun flags, and a level interrupt request.

A host-set skip mode lets a station ignore payload meant for other stations. While skip mode is on, payload characters are dropped completely. They load no data, set no flag and raise no interrupt. The next address character clears skip mode in hardware and is delivered as a normal character with its extra-bit status at 1.

The host compares the address with its own ID. If the address does not match, the host turns skip mode on again. Bit timing comes from a fixed divider that produces 16 sample ticks per bit.

Top module: `mp_uart_rx`

## Requirements
- R1: A character is one low start bit, then DW data bits with the least significant bit first, then one marker bit, then one high stop bit. Each bit lasts 16*OVS_DIV clock cycles, and each bit is sampled at its centre.
- R2: For every character that is accepted while ready_o is 0, data_o takes the data bits and mpb_o takes the marker bit. So mpb_o is 1 after an address character and 0 after a payload character.
- R3: While skip_o is 1, a character whose marker bit is 0 leaves data_o, mpb_o, ready_o, fer_o and ore_o unchanged, and skip_o stays 1. This holds even when the stop bit is bad.
- R4: While skip_o is 1, a character whose marker bit is 1 clears skip_o, loads data_o, sets mpb_o to 1 and sets ready_o.
- R5: irq_o is 1 exactly when rie_i is 1 and ready_o is 1. This covers the ready flag set by an address wake-up.
- R6: An accepted character whose stop bit samples low still loads data_o and sets ready_o, and it also sets fer_o.
- R7: A character accepted while ready_o is already 1 sets ore_o and leaves data_o and mpb_o unchanged.
- R8: A one-cycle pulse on rd_i clears ready_o, on clr_fer_i clears fer_o, and on clr_ore_i clears ore_o. A pulse on skip_set_i sets skip_o.
- R9: After reset, data_o, mpb_o, ready_o, fer_o, ore_o, skip_o and irq_o are all 0.
- R10: A low pulse on the idle line that has ended by the centre of the start bit is discarded, and reception of later characters is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Host read strobe; clears the ready flag |
| clr_fer_i | input | 1 | Clear framing error |
| clr_ore_i | input | 1 | Clear overrun error |
| skip_set_i | input | 1 | Turn skip mode on |
| rie_i | input | 1 | Receive interrupt enable |
| data_o | output | DW | Received data |
| mpb_o | output | 1 | Marker bit of the last accepted character |
| ready_o | output | 1 | Received data is available |
| fer_o | output | 1 | Framing error |
| ore_o | output | 1 | Overrun error |
| skip_o | output | 1 | Skip mode is active |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions check every completed frame against the host-visible state on the next cycle. They confirm that a payload character seen in skip mode changes nothing, and that an address character ends skip mode and sets ready. They also confirm that an accepted character loads its data and marker bit, that an overrun leaves the data alone, and that a read clears ready. Only the bench scenarios show the serial framing itself: bit order, centre sampling, rejection of a short start pulse, and a bad stop bit that is flagged in normal mode but hidden in skip mode.

// File: rtl/mp_rx_pkg.sv
`timescale 1ns/1ps
package mp_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MARK,
    ST_STOP
  } rx_state_e;

  localparam int unsigned OVS = 16;
endpackage

// File: rtl/mp_rx_tick.sv
`timescale 1ns/1ps
module mp_rx_tick #(
  parameter int unsigned OVS_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(OVS_DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_rx_frame.sv
`timescale 1ns/1ps
module mp_rx_frame
  import mp_rx_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          mark_o,
  output logic          stop_ok_o
);
  localparam int unsigned BCW  = $clog2(DW + 1);
  localparam int unsigned PW   = $clog2(OVS);
  localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_e              st_q;
  logic [PW-1:0]          ph_q;
  logic [BCW-1:0]         bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= '0;
      bit_q     <= '0;
      data_o    <= '0;
      mark_o    <= 1'b0;
      stop_ok_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx_s) begin
              st_q <= ST_START;
              ph_q <= '0;
            end
          end
          ST_START: begin
            if (ph_q == MID) begin
              // confirm start at mid-bit, else treat as glitch
              ph_q  <= '0;
              bit_q <= '0;
              st_q  <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          ST_DATA: begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == LAST) begin
              data_o <= {rx_s, data_o[DW-1:1]};
              if (bit_q == BCW'(DW - 1)) st_q <= ST_MARK;
              else bit_q <= bit_q + 1'b1;
            end
          end
          ST_MARK: begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == LAST) begin
              mark_o <= rx_s;
              st_q   <= ST_STOP;
            end
          end
          ST_STOP: begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == LAST) begin
              stop_ok_o <= rx_s;
              done_o    <= 1'b1;
              st_q      <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mp_rx_regs.sv
`timescale 1ns/1ps
module mp_rx_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          mark_i,
  input  logic          stop_ok_i,
  input  logic          rd_i,
  input  logic          clr_fer_i,
  input  logic          clr_ore_i,
  input  logic          skip_set_i,
  input  logic          rie_i,
  output logic [DW-1:0] data_o,
  output logic          mpb_o,
  output logic          ready_o,
  output logic          fer_o,
  output logic          ore_o,
  output logic          skip_o,
  output logic          irq_o
);
  logic accept;

  // in skip mode only an address character gets through
  assign accept = done_i && (!skip_o || mark_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      mpb_o   <= 1'b0;
      ready_o <= 1'b0;
      fer_o   <= 1'b0;
      ore_o   <= 1'b0;
      skip_o  <= 1'b0;
    end else begin
      if (rd_i)       ready_o <= 1'b0;
      if (clr_fer_i)  fer_o   <= 1'b0;
      if (clr_ore_i)  ore_o   <= 1'b0;
      if (skip_set_i) skip_o  <= 1'b1;
      if (accept) begin
        if (skip_o) skip_o <= 1'b0;
        if (ready_o) begin
          ore_o <= 1'b1;
        end else begin
          data_o  <= data_i;
          mpb_o   <= mark_i;
          ready_o <= 1'b1;
          if (!stop_ok_i) fer_o <= 1'b1;
        end
      end
    end
  end

  assign irq_o = rie_i & ready_o;
endmodule

// File: rtl/mp_uart_rx.sv
`timescale 1ns/1ps
module mp_uart_rx #(
  parameter int unsigned DW      = 8,
  parameter int unsigned OVS_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          rd_i,
  input  logic          clr_fer_i,
  input  logic          clr_ore_i,
  input  logic          skip_set_i,
  input  logic          rie_i,
  output logic [DW-1:0] data_o,
  output logic          mpb_o,
  output logic          ready_o,
  output logic          fer_o,
  output logic          ore_o,
  output logic          skip_o,
  output logic          irq_o
);
  logic          tick;
  logic          frm_done;
  logic [DW-1:0] frm_data;
  logic          frm_mark;
  logic          frm_stop_ok;

  mp_rx_tick #(.OVS_DIV(OVS_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  mp_rx_frame #(.DW(DW), .SYNC_STAGES(2)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_i      (rx_i),
    .done_o    (frm_done),
    .data_o    (frm_data),
    .mark_o    (frm_mark),
    .stop_ok_o (frm_stop_ok)
  );

  mp_rx_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frm_done),
    .data_i     (frm_data),
    .mark_i     (frm_mark),
    .stop_ok_i  (frm_stop_ok),
    .rd_i       (rd_i),
    .clr_fer_i  (clr_fer_i),
    .clr_ore_i  (clr_ore_i),
    .skip_set_i (skip_set_i),
    .rie_i      (rie_i),
    .data_o     (data_o),
    .mpb_o      (mpb_o),
    .ready_o    (ready_o),
    .fer_o      (fer_o),
    .ore_o      (ore_o),
    .skip_o     (skip_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
`timescale 1ns/1ps
module mp_uart_rx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          clr_ore_i,
  input logic [DW-1:0] data_o,
  input logic          mpb_o,
  input logic          ready_o,
  input logic          fer_o,
  input logic          ore_o,
  input logic          skip_o,
  input logic          done_i,
  input logic [DW-1:0] fdata_i,
  input logic          fmark_i
);
  // R3
  skip_drops_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o && done_i && !fmark_i |=> skip_o && $stable(data_o) && $stable(mpb_o)
      && !$rose(ready_o) && !$rose(fer_o) && !$rose(ore_o));

  // R4
  addr_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o && done_i && fmark_i && !ready_o |=> !skip_o && mpb_o && ready_o
      && data_o == $past(fdata_i));

  // R2
  accept_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_o && done_i && !ready_o |=> ready_o && mpb_o == $past(fmark_i)
      && data_o == $past(fdata_i));

  // R7
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_o && done_i && ready_o && !rd_i && !clr_ore_i |=> ore_o && $stable(data_o)
      && $stable(mpb_o));

  // R8
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !ready_o);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .clr_ore_i (clr_ore_i),
  .data_o    (data_o),
  .mpb_o     (mpb_o),
  .ready_o   (ready_o),
  .fer_o     (fer_o),
  .ore_o     (ore_o),
  .skip_o    (skip_o),
  .done_i    (frm_done),
  .fdata_i   (frm_data),
  .fmark_i   (frm_mark)
);

// File: tb/test_mp_uart_rx.sv
`timescale 1ns/1ps
module test_mp_uart_rx;
  localparam int unsigned DW      = 8;
  localparam int unsigned OVS_DIV = 4;
  localparam int unsigned BIT     = 16 * OVS_DIV;

  typedef struct {
    logic [DW-1:0] d;
    logic          m;
    logic          f;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, rd = 1'b0, clr_fer = 1'b0, clr_ore = 1'b0, skip_set = 1'b0, rie = 1'b0;
  logic [DW-1:0] data;
  logic mpb, ready, fer, ore, skip, irq;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 1'b0;

  always #2 clk = ~clk;

  mp_uart_rx #(.DW(DW), .OVS_DIV(OVS_DIV)) i_mp_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rd_i(rd), .clr_fer_i(clr_fer),
    .clr_ore_i(clr_ore), .skip_set_i(skip_set), .rie_i(rie), .data_o(data),
    .mpb_o(mpb), .ready_o(ready), .fer_o(fer), .ore_o(ore), .skip_o(skip), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: pushes the expected result, then shifts the frame out
  task automatic send(input logic [DW-1:0] d, input logic m, input bit stop_ok, input bit exp);
    exp_t e;
    if (exp) begin
      e.d = d; e.m = m; e.f = !stop_ok;
      exp_q.push_back(e);
    end
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    rx = m;
    repeat (BIT) @(negedge clk);
    if (stop_ok) begin
      rx = 1'b1;
      repeat (BIT) @(negedge clk);
    end else begin
      rx = 1'b0;
      repeat (BIT * 5 / 8) @(negedge clk);
      rx = 1'b1;
      repeat (BIT * 3 / 8) @(negedge clk);
    end
    repeat (BIT / 4) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor: compares each newly delivered character with the scoreboard
  initial begin
    forever begin
      @(posedge ready);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected ready", data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(data == e.d, "R1 data", data, e.d);
        chk(mpb == e.m, "R2 mpb", mpb, e.m);
        chk(fer == e.f, "R6 fer", fer, e.f);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_test();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(data == 0 && mpb == 0 && ready == 0, "R9 data/mpb/ready", {data, mpb, ready}, 0);
    chk(fer == 0 && ore == 0 && skip == 0 && irq == 0, "R9 flags", {fer, ore, skip, irq}, 0);
    rst_n = 1'b1;
    repeat (BIT) @(negedge clk);

    // R1 R2 payload then address in normal mode
    send(8'hA5, 1'b0, 1'b1, 1'b1);
    chk(ready == 1, "R1 ready", ready, 1);
    pulse_rd();
    @(negedge clk);
    chk(ready == 0, "R8 read clears ready", ready, 0);
    send(8'h3C, 1'b1, 1'b1, 1'b1);
    chk(mpb == 1, "R2 address mpb", mpb, 1);
    pulse_rd();

    // R3 skip mode drops payload, even with a bad stop bit
    @(negedge clk); skip_set = 1'b1;
    @(negedge clk); skip_set = 1'b0;
    chk(skip == 1, "R8 skip set", skip, 1);
    send(8'h11, 1'b0, 1'b1, 1'b0);
    chk(ready == 0 && data == 8'h3C && skip == 1, "R3 payload ignored", {ready, data, skip}, {1'b0, 8'h3C, 1'b1});
    send(8'h22, 1'b0, 1'b0, 1'b0);
    chk(fer == 0 && ore == 0 && ready == 0, "R3 no flags in skip", {fer, ore, ready}, 0);
    chk(mpb == 1 && data == 8'h3C, "R3 mpb/data kept", {mpb, data}, {1'b1, 8'h3C});

    // R4 R5 address wakes the receiver and raises the interrupt
    rie = 1'b1;
    send(8'h42, 1'b1, 1'b1, 1'b1);
    chk(skip == 0, "R4 skip cleared", skip, 0);
    chk(ready == 1 && mpb == 1, "R4 ready/mpb", {ready, mpb}, 2'b11);
    chk(irq == 1, "R5 irq on wake", irq, 1);
    pulse_rd();
    @(negedge clk);
    chk(irq == 0, "R5 irq drops on read", irq, 0);
    rie = 1'b0;

    // R6 framing error in normal mode
    send(8'h77, 1'b0, 1'b0, 1'b1);
    chk(fer == 1 && ready == 1, "R6 fer set", {fer, ready}, 2'b11);
    @(negedge clk); clr_fer = 1'b1;
    @(negedge clk); clr_fer = 1'b0;
    chk(fer == 0, "R8 clr fer", fer, 0);
    pulse_rd();

    // R7 overrun keeps the first character
    send(8'h10, 1'b0, 1'b1, 1'b1);
    send(8'h20, 1'b1, 1'b1, 1'b0);
    chk(ore == 1, "R7 ore set", ore, 1);
    chk(data == 8'h10 && mpb == 0, "R7 data kept", {data, mpb}, {8'h10, 1'b0});
    @(negedge clk); clr_ore = 1'b1;
    @(negedge clk); clr_ore = 1'b0;
    chk(ore == 0, "R8 clr ore", ore, 0);
    pulse_rd();

    // R10 short low pulse on the idle line is discarded
    @(negedge clk); rx = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rx = 1'b1;
    repeat (BIT * 2) @(negedge clk);
    chk(ready == 0, "R10 glitch rejected", ready, 0);
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    chk(ready == 1 && data == 8'h5A, "R10 next frame ok", {ready, data}, {1'b1, 8'h5A});
    pulse_rd();

    repeat (BIT) @(negedge clk);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    finish_test();
  end
endmodule